// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns up to 32 general-purpose input pins into a single interrupt line for one port. Each pin carries a two-bit trigger selection (active-high level, active-low level, rising edge, falling edge), a mask bit and a sticky pending bit. The pins are synchronised into the clock domain. They are sampled on sample ticks, at one of two selectable rates, and a pin that meets its trigger condition while unmasked latches its pending bit. Software reads and clears the pending bits, and a port-level control word enables the output and acknowledges the port.

Software reaches the block through a small register bus: single-cycle writes, and reads whose data comes back one cycle later with a valid strobe. A three-state port machine drives the port-level pending flag in the control word:

- `PS_QUIET`: no pin is pending.
- `PS_SIGNAL`: at least one pin is pending and the port has not been acknowledged. The flag reads 1.
- `PS_HELD`: the port has been acknowledged but pins are still pending. The flag reads 0.

Its transitions are:

- QUIET→SIGNAL on any pin event.
- SIGNAL→HELD on an acknowledge when no event arrives in the same cycle.
- SIGNAL→QUIET and HELD→QUIET when the last pending bit clears.
- HELD→SIGNAL on any fresh pin event.

Only one edge polarity can be armed per pin. Software that needs both edges has to re-arm the opposite edge itself.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the control, pending, mask and both trigger words read zero, and `irq_o` is low. This leaves every pin masked, the port disabled, slow sampling selected and every trigger set to active-high level.
- R2: Byte address 0x10 holds the trigger fields of pins 0–15 and 0x0C holds pins 16–31. Each pin's field sits at bits (pin mod 16)×2 +: 2, encoded 0 = level high, 1 = level low, 2 = rising edge, 3 = falling edge.
- R3: A level-triggered unmasked pin sets its pending bit on every sample tick while its level is active, so a clear while the level persists is overridden at once.
- R4: An edge-triggered pin reacts only to its armed polarity: a rising-type pin ignores falling transitions, and a falling-type pin ignores rising ones.
- R5: A pin whose mask bit (address 0x08, bit = pin) is 0 never sets its pending bit.
- R6: Writing 1 to a bit of the pending word (address 0x04) clears that bit, and writing 0 leaves it unchanged. A new pin event in the same cycle as the clear wins.
- R7: `irq_o` is high exactly when the enable bit (control bit 1, address 0x00) is set and at least one pending bit is set.
- R8: Control bit 0 reads 1 in `PS_SIGNAL` only. Writing 1 to it acknowledges the port, so it reads 0 while pins stay pending. A new pin event raises it again, and it stays 0 once all pins are cleared.
- R9: Register bits belonging to pins at or above `PIN_COUNT` read as zero in the pending, mask and trigger words and cannot be written.
- R10: Control bit 2 = 1 samples the pins every clock. Bit 2 = 0 samples once every `SLOW_DIV` clocks.
- R11: In fast sampling, a pin change driven before clock edge N shows in the pending word and `irq_o` after edge N+2 (two synchroniser stages, then the pending register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | PIN_COUNT | Asynchronous pin levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq_o | output | 1 | Port interrupt request |

## Verification
The bench targets the acknowledge path:
- It acknowledges while an edge-triggered pin stays pending, then raises a second pin. A machine that never enters the held state would keep the flag at 1, and one that never leaves it would miss the fresh event.

It targets the trigger encoding and pin mapping:
- It clears a still-active level pin and reads it back as pending. A design that let the clear beat the event would return zero.
- It drives the wrong polarity on each edge pin. A swapped or both-edge detector would latch pending there.
- It uses a pin in the upper trigger word. A design that swapped the two trigger words would arm the wrong pins.

It also checks the exact two-edge latency, writes all-ones to every word of a 30-pin port to expose unmasked upper bits, and confirms that a disabled port holds `irq_o` low while still latching pending bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        PS_QUIET  = 2'd0,
        PS_SIGNAL = 2'd1,
        PS_HELD   = 2'd2
    } port_state_e;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_TYPE_HI = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_TYPE_LO = 5'h10;

    localparam int unsigned CTRL_PEND_BIT = 0;
    localparam int unsigned CTRL_EN_BIT   = 1;
    localparam int unsigned CTRL_FAST_BIT = 2;

    localparam int unsigned PINS_PER_TYPE_WORD = 16;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // two-stage synchroniser per pin
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [1:0] stage_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= 2'b00;
            end else begin
                stage_q <= {stage_q[0], d_i[b]};
            end
        end

        assign q_o[b] = stage_q[1];
    end

endmodule

// File: rtl/gpio_irq_tick.sv
module gpio_irq_tick #(
    parameter int unsigned SLOW_DIV = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_i,
    output logic tick_o
);

    localparam int unsigned CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = fast_i | (cnt_q == LAST);

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [WIDTH-1:0]      lvl_i,
    input  logic [WIDTH-1:0][1:0] trig_i,
    input  logic [WIDTH-1:0]      mask_i,
    output logic [WIDTH-1:0]      hit_o
);

    logic [WIDTH-1:0] samp_q;

    // previous sample, refreshed only on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else if (tick_i) begin
            samp_q <= lvl_i;
        end
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic cond;

        always_comb begin
            unique case (trig_e'(trig_i[p]))
                TRIG_LVL_HI: cond = lvl_i[p];
                TRIG_LVL_LO: cond = ~lvl_i[p];
                TRIG_RISE:   cond = lvl_i[p] & ~samp_q[p];
                TRIG_FALL:   cond = ~lvl_i[p] & samp_q[p];
                default:     cond = 1'b0;
            endcase
        end

        assign hit_o[p] = tick_i & mask_i[p] & cond;
    end

endmodule

// File: rtl/gpio_irq_port_fsm.sv
module gpio_irq_port_fsm
    import gpio_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_next_i,
    input  logic        new_hit_i,
    input  logic        ack_i,
    output logic        flag_o,
    output port_state_e state_o
);

    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_QUIET: begin
                if (new_hit_i) state_d = PS_SIGNAL;
            end
            PS_SIGNAL: begin
                if (!any_next_i)                 state_d = PS_QUIET;
                else if (ack_i && !new_hit_i)    state_d = PS_HELD;
            end
            PS_HELD: begin
                if (!any_next_i)     state_d = PS_QUIET;
                else if (new_hit_i)  state_d = PS_SIGNAL;
            end
            default: state_d = PS_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag_o  = (state_q == PS_SIGNAL);
        state_o = state_q;
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 32,
    parameter int unsigned SLOW_DIV  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pin_i,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [4:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic                 irq_o
);

    localparam int unsigned HALF = PINS_PER_TYPE_WORD;

    logic                      en_q, fast_q;
    logic [PIN_COUNT-1:0]      mask_q, pend_q, pend_d;
    logic [PIN_COUNT-1:0][1:0] trig_q;
    logic [PIN_COUNT-1:0]      sync_lvl, hit, clr;
    logic                      tick, ack, ctrl_pend;
    port_state_e               state;
    logic [WORD_W-1:0]         rd_word, type_lo_w, type_hi_w;

    logic wr_ctrl, wr_pend, wr_mask, wr_thi, wr_tlo;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_pend = bus_wr && (bus_addr == OFS_PEND);
        wr_mask = bus_wr && (bus_addr == OFS_MASK);
        wr_thi  = bus_wr && (bus_addr == OFS_TYPE_HI);
        wr_tlo  = bus_wr && (bus_addr == OFS_TYPE_LO);
    end

    gpio_irq_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_lvl)
    );

    gpio_irq_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .fast_i (fast_q),
        .tick_o (tick)
    );

    gpio_irq_detect #(.WIDTH(PIN_COUNT)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .lvl_i  (sync_lvl),
        .trig_i (trig_q),
        .mask_i (mask_q),
        .hit_o  (hit)
    );

    // control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            fast_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= bus_wdata[CTRL_EN_BIT];
            fast_q <= bus_wdata[CTRL_FAST_BIT];
        end
    end

    assign ack = wr_ctrl & bus_wdata[CTRL_PEND_BIT];

    // mask word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= bus_wdata[PIN_COUNT-1:0];
        end
    end

    // trigger fields, low pins in the upper-offset word
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_trig
        localparam int unsigned POS = (p % HALF) * 2;
        localparam bit IN_LO = (p < HALF);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trig_q[p] <= TRIG_LVL_HI;
            end else if (IN_LO ? wr_tlo : wr_thi) begin
                trig_q[p] <= bus_wdata[POS +: 2];
            end
        end
    end

    // pending: event beats write-1-to-clear
    assign clr    = wr_pend ? bus_wdata[PIN_COUNT-1:0] : '0;
    assign pend_d = (pend_q & ~clr) | hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    gpio_irq_port_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_next_i (|pend_d),
        .new_hit_i  (|hit),
        .ack_i      (ack),
        .flag_o     (ctrl_pend),
        .state_o    (state)
    );

    assign irq_o = en_q & (|pend_q);

    // read path
    always_comb begin
        type_lo_w = '0;
        type_hi_w = '0;
        for (int p = 0; p < PIN_COUNT; p++) begin
            if (p < HALF) begin
                type_lo_w[(p % HALF) * 2 +: 2] = trig_q[p];
            end else begin
                type_hi_w[(p % HALF) * 2 +: 2] = trig_q[p];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                rd_word[CTRL_PEND_BIT] = ctrl_pend;
                rd_word[CTRL_EN_BIT]   = en_q;
                rd_word[CTRL_FAST_BIT] = fast_q;
            end
            OFS_PEND:    rd_word = WORD_W'(pend_q);
            OFS_MASK:    rd_word = WORD_W'(mask_q);
            OFS_TYPE_HI: rd_word = type_hi_w;
            OFS_TYPE_LO: rd_word = type_lo_w;
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                bus_rdata <= rd_word;
            end
        end
    end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 32,
    parameter int unsigned SLOW_DIV  = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [4:0]           bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [PIN_COUNT-1:0] pend_q,
    input logic [PIN_COUNT-1:0] mask_q,
    input logic [PIN_COUNT-1:0] hit,
    input logic                 tick,
    input logic                 fast_q,
    input logic                 en_q,
    input logic                 ctrl_pend,
    input logic                 irq_o
);

    // R5
    masked_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PEND) |=>
        ((pend_q & $past(bus_wdata[PIN_COUNT-1:0]) & ~$past(hit)) == '0));

    // R8
    ack_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_PEND_BIT] && hit == '0)
        |=> !ctrl_pend);

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_o);

    // R10
    slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SLOW_DIV > 1 && tick && !fast_q) |=> (!tick || fast_q));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .PIN_COUNT (PIN_COUNT),
    .SLOW_DIV  (SLOW_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .hit       (hit),
    .tick      (tick),
    .fast_q    (fast_q),
    .en_q      (en_q),
    .ctrl_pend (ctrl_pend),
    .irq_o     (irq_o)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

    localparam int unsigned NP  = 30;
    localparam int unsigned DIV = 8;

    localparam logic [4:0] A_CTRL = 5'h00, A_PEND = 5'h04, A_MASK = 5'h08,
                           A_THI = 5'h0C, A_TLO = 5'h10;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, irq_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t sb_q[$];
    exp_t cur;

    always #5 clk = ~clk;

    gpio_irq_port #(.PIN_COUNT(NP), .SLOW_DIV(DIV)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_in),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_o      (irq_o)
    );

    // monitor: pop expected read data as responses arrive
    always @(negedge clk) begin
        if (bus_rvalid) begin
            n_tests++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read response: actual %h expected none", bus_rdata);
            end else begin
                cur = sb_q.pop_front();
                if (bus_rdata !== cur.data) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", cur.tag, bus_rdata, cur.data);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issue a read and push the expected value
    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        exp_t x;
        x.data = e;
        x.tag  = tag;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        sb_q.push_back(x);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_tests++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s: actual irq %b expected %b", tag, irq_o, e);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(A_CTRL, 32'h0, "R1 ctrl reset");
        rd(A_PEND, 32'h0, "R1 pend reset");
        rd(A_MASK, 32'h0, "R1 mask reset");
        rd(A_THI,  32'h0, "R1 type_hi reset");
        rd(A_TLO,  32'h0, "R1 type_lo reset");

        // R9 bits above pin count
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, 32'h3FFF_FFFF, "R9 mask upper bits");
        wr(A_THI, 32'hFFFF_FFFF);
        rd(A_THI, 32'h0FFF_FFFF, "R9 type_hi upper fields");
        wr(A_TLO, 32'hFFFF_FFFF);
        rd(A_TLO, 32'hFFFF_FFFF, "R9 type_lo full");
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, 32'h0, "R9 pend after clear-all");
        wr(A_MASK, 32'h0);
        wr(A_THI, 32'h0);
        wr(A_TLO, 32'h0);

        // R2 layout: pin3 rising in low-pin word, pin20 falling in high-pin word
        wr(A_CTRL, 32'h6);
        wr(A_TLO, 32'h2 << 6);
        wr(A_THI, 32'h3 << 8);
        wr(A_MASK, (32'h1 << 3) | (32'h1 << 20));
        idle(4);
        rd(A_PEND, 32'h0, "R2 no event with pins low");

        // R11 latency
        pin_in[3] = 1'b1;
        idle(2);
        chk_irq(1'b0, "R11 irq not before two edges");
        idle(1);
        chk_irq(1'b1, "R11 irq after third edge");
        rd(A_PEND, 32'h8, "R4 rising pin3 pending");
        rd(A_CTRL, 32'h7, "R8 flag set in signal state");

        // R6 write-0 no effect, write-1 clears
        wr(A_PEND, 32'h0);
        rd(A_PEND, 32'h8, "R6 write zero keeps pending");
        wr(A_PEND, 32'h8);
        rd(A_PEND, 32'h0, "R6 write one clears");
        chk_irq(1'b0, "R7 irq low with nothing pending");
        rd(A_CTRL, 32'h6, "R8 flag low when quiet");

        // R4 opposite polarities
        pin_in[3] = 1'b0;
        idle(5);
        rd(A_PEND, 32'h0, "R4 falling edge ignored on rising pin");
        pin_in[20] = 1'b1;
        idle(5);
        rd(A_PEND, 32'h0, "R4 rising edge ignored on falling pin");
        pin_in[20] = 1'b0;
        idle(5);
        rd(A_PEND, 32'h1 << 20, "R2 pin20 falling from high word");
        wr(A_PEND, 32'hFFFF_FFFF);

        // R8 acknowledge, held, re-raise
        pin_in[3] = 1'b1;
        idle(5);
        rd(A_CTRL, 32'h7, "R8 flag raised by pin3");
        wr(A_CTRL, 32'h7);
        rd(A_CTRL, 32'h6, "R8 flag cleared by ack while pending");
        rd(A_PEND, 32'h8, "R8 pin pending kept after ack");
        chk_irq(1'b1, "R7 irq stays high after ack");
        pin_in[20] = 1'b1;
        idle(5);
        rd(A_CTRL, 32'h6, "R8 no re-raise without event");
        pin_in[20] = 1'b0;
        idle(5);
        rd(A_CTRL, 32'h7, "R8 new event re-raises flag");
        rd(A_PEND, (32'h1 << 20) | 32'h8, "R8 both pins pending");
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h6, "R8 flag low after full clear");
        pin_in[3] = 1'b0;
        idle(5);

        // R7 enable gating
        wr(A_CTRL, 32'h4);
        pin_in[3] = 1'b1;
        idle(5);
        rd(A_PEND, 32'h8, "R7 pending latched while disabled");
        chk_irq(1'b0, "R7 irq low while disabled");
        wr(A_CTRL, 32'h6);
        chk_irq(1'b1, "R7 irq high once enabled");
        wr(A_PEND, 32'hFFFF_FFFF);

        // R5 mask gating
        wr(A_MASK, 32'h0);
        pin_in[3] = 1'b0;
        idle(5);
        pin_in[3] = 1'b1;
        idle(5);
        rd(A_PEND, 32'h0, "R5 masked pin ignored");
        chk_irq(1'b0, "R5 irq low for masked pin");

        // R3 level high, clear while active is overridden
        wr(A_MASK, 32'h1 << 5);
        pin_in[5] = 1'b1;
        idle(5);
        rd(A_PEND, 32'h20, "R3 level high pending");
        wr(A_PEND, 32'h20);
        rd(A_PEND, 32'h20, "R3 level still active re-sets");
        pin_in[5] = 1'b0;
        idle(5);
        wr(A_PEND, 32'h20);
        rd(A_PEND, 32'h0, "R3 level inactive clears");

        // R3 level low
        wr(A_TLO, (32'h2 << 6) | (32'h1 << 10));
        idle(5);
        rd(A_PEND, 32'h20, "R3 level low pending");
        pin_in[5] = 1'b1;
        idle(5);
        wr(A_PEND, 32'h20);
        rd(A_PEND, 32'h0, "R3 level low released");

        // R10 slow sampling
        wr(A_TLO, 32'h2 << 10);
        wr(A_CTRL, 32'h2);
        pin_in[5] = 1'b0;
        idle(3 * DIV);
        rd(A_PEND, 32'h0, "R4 falling ignored in slow mode");
        pin_in[5] = 1'b1;
        idle(DIV + 4);
        rd(A_PEND, 32'h20, "R10 slow sampling catches edge");
        rd(A_CTRL, 32'h3, "R10 slow mode control readback");

        idle(3);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule